// File: doc/BRIEF.md
# Paired-Page Address Translation Buffer

This block is a fully associative translation buffer for a 32-bit virtual address space. Each entry maps two neighbouring virtual pages, an even page and an odd page, and both share one tag, one address-space identifier and one page size. The page size is set per entry by a mask. The smallest page is 4 KB, so the smallest pair covers 8 KB. A lookup presents a virtual address, a read/write flag and the current 8-bit address-space identifier. One cycle later the block returns a result code, a physical address and read and write permissions.

The entries are loaded through a simple write port that takes an index and a full entry: tag, page mask, identifier, global flag, and a frame base with valid and dirty flags for each of the two halves. The result code tells the caller what went wrong. A miss means no entry covers the address. Invalid means the chosen half is not valid. Modify means a store hit a clean page. The caller can then raise the matching fault.

Top module: `pairtlb_top`

## Requirements
- R1: An entry takes part in a lookup when its global flag is set or its stored identifier equals `cur_asid`, and when the address and the stored tag are equal after both are cleared under the entry's effective mask.
- R2: The effective mask is the stored page mask ORed with 0x1FFF. A page mask of zero therefore gives 4 KB pages, and 0x6000 gives 16 KB pages.
- R3: The half is chosen by the address bit at the highest set position of the effective mask (bit 12 for 4 KB pages, bit 14 for 16 KB pages). A one selects the odd half (frame 1, valid 1, dirty 1) and a zero selects the even half.
- R4: If the chosen half has its valid flag clear, `rsp_code` is 2'b10 (invalid), whatever the access kind.
- R5: A write whose chosen half is valid but clean gives `rsp_code` 2'b11 (modify). A read of a valid half always gives 2'b00 (success).
- R6: On success, `rsp_pa` is the chosen frame base ORed with the address bits under the half-mask (the effective mask shifted right by one).
- R7: On success, `rsp_rd` is 1 and `rsp_wr` equals the chosen dirty flag. On any other code, `rsp_rd`, `rsp_wr` and `rsp_pa` are all zero.
- R8: If no entry takes part, `rsp_code` is 2'b01 (miss).
- R9: When several entries match, the lowest index decides the result, even when that entry's chosen half is invalid.
- R10: `rsp_valid` is high in exactly the cycles after those in which `req_valid` was high. The response reflects the entry contents at the time of the request.
- R11: After reset every entry holds all-zero fields, so both valid flags and the global flag are clear, and `rsp_valid` is low.
- R12: A write through the load port at `wr_idx` replaces that entry completely. The new contents are seen by lookups requested from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a store, 0 for a load |
| cur_asid | input | 8 | Current address-space identifier |
| wr_en | input | 1 | Load-port strobe |
| wr_idx | input | IDX_W | Entry index to load |
| wr_vpn2 | input | 32 | Tag of the page pair (address form) |
| wr_pmask | input | 32 | Page-size mask above the 8 KB pair |
| wr_asid | input | 8 | Identifier of the entry |
| wr_global | input | 1 | Entry matches any identifier |
| wr_pfn0 | input | 32 | Even-half physical frame base |
| wr_v0 | input | 1 | Even-half valid |
| wr_d0 | input | 1 | Even-half dirty (writable) |
| wr_pfn1 | input | 32 | Odd-half physical frame base |
| wr_v1 | input | 1 | Odd-half valid |
| wr_d1 | input | 1 | Odd-half dirty (writable) |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_code | output | 2 | 00 success, 01 miss, 10 invalid, 11 modify |
| rsp_pa | output | 32 | Translated physical address |
| rsp_rd | output | 1 | Read permission |
| rsp_wr | output | 1 | Write permission |

## Verification
The bench builds the block with the default 16 entries. This puts index 15 in reach, so the highest slot is tested along with the low ones, and the untouched reset entries in between test the zero-tag, zero-identifier case. It loads both 4 KB and 16 KB entries, which covers two positions of the half-select bit and two widths of offset pass-through. It also loads overlapping entries that differ only in identifier or index, which exercises the identifier filter and the lowest-index rule, including the case where the winning entry is invalid.

// File: rtl/pairtlb_pkg.sv
package pairtlb_pkg;

    localparam int VA_W      = 32;
    localparam int PA_W      = 32;
    localparam int ASID_W    = 8;
    localparam int PAIR_BITS = 13;   // 4 KB page pair: low offset bits always under the mask

    localparam logic [VA_W-1:0] PAIR_MASK = VA_W'((64'd1 << PAIR_BITS) - 64'd1);

    typedef enum logic [1:0] {
        CODE_OK      = 2'b00,
        CODE_MISS    = 2'b01,
        CODE_INVALID = 2'b10,
        CODE_MODIFY  = 2'b11
    } rsp_code_e;

    typedef struct packed {
        logic [VA_W-1:0]   vpn2;
        logic [VA_W-1:0]   pmask;
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic [PA_W-1:0]   pfn1;
        logic              v1;
        logic              d1;
        logic [PA_W-1:0]   pfn0;
        logic              v0;
        logic              d0;
    } tlb_entry_t;

    typedef struct packed {
        logic            valid;
        rsp_code_e       code;
        logic [PA_W-1:0] pa;
        logic            rd;
        logic            wr;
    } tlb_rsp_t;

endpackage

// File: rtl/pairtlb_store.sv
module pairtlb_store
    import pairtlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  tlb_entry_t                   wr_entry,
    output tlb_entry_t [ENTRIES-1:0]     entries
);

    tlb_entry_t [ENTRIES-1:0] ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        if (wr_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == wr_idx) begin
                    ent_d[i] = wr_entry;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_q <= '0;
        end else begin
            ent_q <= ent_d;
        end
    end

    assign entries = ent_q;

endmodule

// File: rtl/pairtlb_cmp.sv
module pairtlb_cmp
    import pairtlb_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  tlb_entry_t [ENTRIES-1:0]          entries,
    input  logic [VA_W-1:0]                   va,
    input  logic [ASID_W-1:0]                 asid,
    output logic [ENTRIES-1:0]                hit,
    output logic [ENTRIES-1:0]                odd,
    output logic [ENTRIES-1:0][VA_W-1:0]      half_mask
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic [VA_W-1:0] eff_mask;
        logic [VA_W-1:0] hmask;
        logic            id_ok;
        logic            tag_ok;

        always_comb begin
            eff_mask = entries[g].pmask | PAIR_MASK;
            hmask    = eff_mask >> 1;
            id_ok    = entries[g].glob || (entries[g].asid == asid);
            tag_ok   = ((va & ~eff_mask) == (entries[g].vpn2 & ~eff_mask));
        end

        assign hit[g]       = id_ok && tag_ok;
        assign odd[g]       = |(va & eff_mask & ~hmask);
        assign half_mask[g] = hmask;
    end

endmodule

// File: rtl/pairtlb_pick.sv
module pairtlb_pick #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] hit,
    output logic               any_hit,
    output logic [IDX_W-1:0]   sel
);

    always_comb begin
        sel = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit[i]) begin
                sel = IDX_W'(i);
            end
        end
        any_hit = |hit;
    end

endmodule

// File: rtl/pairtlb_top.sv
module pairtlb_top
    import pairtlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [31:0]       req_va,
    input  logic              req_write,
    input  logic [7:0]        cur_asid,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [31:0]       wr_vpn2,
    input  logic [31:0]       wr_pmask,
    input  logic [7:0]        wr_asid,
    input  logic              wr_global,
    input  logic [31:0]       wr_pfn0,
    input  logic              wr_v0,
    input  logic              wr_d0,
    input  logic [31:0]       wr_pfn1,
    input  logic              wr_v1,
    input  logic              wr_d1,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic [31:0]       rsp_pa,
    output logic              rsp_rd,
    output logic              rsp_wr
);

    tlb_entry_t                     wr_entry;
    tlb_entry_t [ENTRIES-1:0]       entries;
    logic [ENTRIES-1:0]             hit;
    logic [ENTRIES-1:0]             odd;
    logic [ENTRIES-1:0][VA_W-1:0]   half_mask;
    logic                           any_hit;
    logic [IDX_W-1:0]               sel;

    tlb_rsp_t rsp_d, rsp_q;

    always_comb begin
        wr_entry       = '0;
        wr_entry.vpn2  = wr_vpn2;
        wr_entry.pmask = wr_pmask;
        wr_entry.asid  = wr_asid;
        wr_entry.glob  = wr_global;
        wr_entry.pfn0  = wr_pfn0;
        wr_entry.v0    = wr_v0;
        wr_entry.d0    = wr_d0;
        wr_entry.pfn1  = wr_pfn1;
        wr_entry.v1    = wr_v1;
        wr_entry.d1    = wr_d1;
    end

    pairtlb_store #(.ENTRIES(ENTRIES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_entry (wr_entry),
        .entries  (entries)
    );

    pairtlb_cmp #(.ENTRIES(ENTRIES)) u_cmp (
        .entries   (entries),
        .va        (req_va),
        .asid      (cur_asid),
        .hit       (hit),
        .odd       (odd),
        .half_mask (half_mask)
    );

    pairtlb_pick #(.ENTRIES(ENTRIES)) u_pick (
        .hit     (hit),
        .any_hit (any_hit),
        .sel     (sel)
    );

    // Resolve the winning entry into a response.
    always_comb begin
        tlb_entry_t      win;
        logic            half_odd;
        logic            half_v;
        logic            half_d;
        logic [PA_W-1:0] half_pfn;
        logic [VA_W-1:0] hm;

        win      = entries[sel];
        half_odd = odd[sel];
        hm       = half_mask[sel];
        half_v   = half_odd ? win.v1   : win.v0;
        half_d   = half_odd ? win.d1   : win.d0;
        half_pfn = half_odd ? win.pfn1 : win.pfn0;

        rsp_d       = '0;
        rsp_d.valid = req_valid;
        rsp_d.code  = CODE_MISS;
        if (req_valid && any_hit) begin
            if (!half_v) begin
                rsp_d.code = CODE_INVALID;
            end else if (req_write && !half_d) begin
                rsp_d.code = CODE_MODIFY;
            end else begin
                rsp_d.code = CODE_OK;
                rsp_d.pa   = half_pfn | PA_W'(req_va & hm);
                rsp_d.rd   = 1'b1;
                rsp_d.wr   = half_d;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_code  = rsp_q.code;
    assign rsp_pa    = rsp_q.pa;
    assign rsp_rd    = rsp_q.rd;
    assign rsp_wr    = rsp_q.wr;

endmodule

// File: rtl/pairtlb_chk.sv
module pairtlb_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic        rsp_valid,
    input logic [1:0]  rsp_code,
    input logic [31:0] rsp_pa,
    input logic        rsp_rd,
    input logic        rsp_wr
);

    // R10
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R10
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R7
    success_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'b00) |-> rsp_rd);

    // R7
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code != 2'b00) |-> (!rsp_rd && !rsp_wr && rsp_pa == 32'h0));

    // R5
    read_never_modify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> (rsp_code != 2'b11));

    // R5
    store_ok_writable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_code != 2'b00 || rsp_wr));

endmodule

bind pairtlb_top pairtlb_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .rsp_code  (rsp_code),
    .rsp_pa    (rsp_pa),
    .rsp_rd    (rsp_rd),
    .rsp_wr    (rsp_wr)
);

// File: tb/pairtlb_top_tb.sv
module pairtlb_top_tb;

    localparam int ENTRIES = 16;
    localparam int IDX_W   = $clog2(ENTRIES);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [31:0]       req_va = '0;
    logic              req_write = 1'b0;
    logic [7:0]        cur_asid = '0;
    logic              wr_en = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [31:0]       wr_vpn2 = '0;
    logic [31:0]       wr_pmask = '0;
    logic [7:0]        wr_asid = '0;
    logic              wr_global = 1'b0;
    logic [31:0]       wr_pfn0 = '0;
    logic              wr_v0 = 1'b0;
    logic              wr_d0 = 1'b0;
    logic [31:0]       wr_pfn1 = '0;
    logic              wr_v1 = 1'b0;
    logic              wr_d1 = 1'b0;
    logic              rsp_valid;
    logic [1:0]        rsp_code;
    logic [31:0]       rsp_pa;
    logic              rsp_rd;
    logic              rsp_wr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    pairtlb_top #(.ENTRIES(ENTRIES)) u_dut (.*);

    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic [7:0]  asid;
        logic [1:0]  code;
        logic [31:0] pa;
        logic        rd;
        logic        wp;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{32'h0040_0123, 1'b0, 8'd5, 2'b00, 32'h1000_0123, 1'b1, 1'b1}, // R3 even, R6, R7
        '{32'h0040_1ABC, 1'b0, 8'd5, 2'b00, 32'h1000_1ABC, 1'b1, 1'b0}, // R3 odd, R5 read clean
        '{32'h0040_1ABC, 1'b1, 8'd5, 2'b11, 32'h0,         1'b0, 1'b0}, // R5 modify
        '{32'h0040_0010, 1'b1, 8'd5, 2'b00, 32'h1000_0010, 1'b1, 1'b1}, // R7 store ok
        '{32'h0040_0123, 1'b0, 8'd7, 2'b00, 32'h5000_0123, 1'b1, 1'b1}, // R1 asid picks entry 2
        '{32'h0040_0123, 1'b0, 8'd9, 2'b01, 32'h0,         1'b0, 1'b0}, // R8 asid miss
        '{32'h2000_3FFC, 1'b0, 8'd9, 2'b10, 32'h0,         1'b0, 1'b0}, // R4 global even invalid
        '{32'h2000_7FF0, 1'b1, 8'd9, 2'b00, 32'h3100_3FF0, 1'b1, 1'b1}, // R2 R3 16K odd
        '{32'h2000_4000, 1'b0, 8'd0, 2'b00, 32'h3100_0000, 1'b1, 1'b1}, // R3 bit 14
        '{32'h2000_8000, 1'b0, 8'd9, 2'b01, 32'h0,         1'b0, 1'b0}, // R2 beyond pair
        '{32'h0060_0FFF, 1'b1, 8'd3, 2'b00, 32'h6000_0FFF, 1'b1, 1'b1}, // R1 global index 15
        '{32'h0060_1000, 1'b0, 8'd3, 2'b10, 32'h0,         1'b0, 1'b0}, // R4 odd invalid
        '{32'h0000_0000, 1'b0, 8'd0, 2'b10, 32'h0,         1'b0, 1'b0}, // R11 reset entry
        '{32'h0000_0000, 1'b0, 8'd1, 2'b01, 32'h0,         1'b0, 1'b0}, // R8 R11
        '{32'h0041_0000, 1'b0, 8'd5, 2'b01, 32'h0,         1'b0, 1'b0}  // R1 tag mismatch
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load(input int idx, input logic [31:0] vpn, input logic [31:0] pm,
                        input logic [7:0] asid, input logic g,
                        input logic [31:0] p0, input logic v0, input logic d0,
                        input logic [31:0] p1, input logic v1, input logic d1);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_vpn2 = vpn; wr_pmask = pm;
        wr_asid = asid; wr_global = g;
        wr_pfn0 = p0; wr_v0 = v0; wr_d0 = d0;
        wr_pfn1 = p1; wr_v1 = v1; wr_d1 = d1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input string req, input logic [31:0] va, input logic w,
                        input logic [7:0] asid, input logic [1:0] code,
                        input logic [31:0] pa, input logic rd, input logic wp);
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_write = w; cur_asid = asid;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        chk({req, " valid"}, 64'(rsp_valid), 64'd1);
        chk({req, " code"},  64'(rsp_code),  64'(code));
        chk({req, " pa"},    64'(rsp_pa),    64'(pa));
        chk({req, " perms"}, 64'({rsp_rd, rsp_wp_dummy(rsp_wr)}), 64'({rd, wp}));
    endtask

    function automatic logic rsp_wp_dummy(input logic x);
        return x;
    endfunction

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R11 rsp_valid low in reset", 64'(rsp_valid), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R10 no response without request", 64'(rsp_valid), 64'd0);

        // R11: empty entries are zero: VA 0 with identifier 0 matches, half invalid
        look("R11 zero entry", 32'h0, 1'b0, 8'd0, 2'b10, 32'h0, 1'b0, 1'b0);
        look("R11 R8 empty miss", 32'h0040_0123, 1'b0, 8'd5, 2'b01, 32'h0, 1'b0, 1'b0);

        load(0,  32'h0040_0000, 32'h0, 8'd5, 1'b0, 32'h1000_0000, 1'b1, 1'b1, 32'h1000_1000, 1'b1, 1'b0);
        load(1,  32'h2000_0000, 32'h0000_6000, 8'd0, 1'b1, 32'h3000_0000, 1'b0, 1'b0, 32'h3100_0000, 1'b1, 1'b1);
        load(2,  32'h0040_0000, 32'h0, 8'd7, 1'b0, 32'h5000_0000, 1'b1, 1'b1, 32'h5000_1000, 1'b1, 1'b1);
        load(3,  32'h0040_0000, 32'h0, 8'd5, 1'b0, 32'h7000_0000, 1'b1, 1'b1, 32'h7000_1000, 1'b1, 1'b1);
        load(15, 32'h0060_0000, 32'h0, 8'd0, 1'b1, 32'h6000_0000, 1'b1, 1'b1, 32'h0,         1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            look($sformatf("R1-vector %0d", i), VECS[i].va, VECS[i].wr, VECS[i].asid,
                 VECS[i].code, VECS[i].pa, VECS[i].rd, VECS[i].wp);
        end

        // R9: entry 0 wins over entry 3 even when its half is invalid
        load(0, 32'h0040_0000, 32'h0, 8'd5, 1'b0, 32'h1000_0000, 1'b0, 1'b0, 32'h1000_1000, 1'b1, 1'b0);
        look("R9 low index invalid wins", 32'h0040_0123, 1'b0, 8'd5, 2'b10, 32'h0, 1'b0, 1'b0);

        // R12: moving entry 0 away lets entry 3 serve the address
        load(0, 32'h0090_0000, 32'h0, 8'd5, 1'b0, 32'h1000_0000, 1'b1, 1'b1, 32'h1000_1000, 1'b1, 1'b0);
        look("R12 R9 rewrite exposes entry 3", 32'h0040_0123, 1'b0, 8'd5, 2'b00, 32'h7000_0123, 1'b1, 1'b1);
        look("R12 new tag served", 32'h0090_1004, 1'b0, 8'd5, 2'b00, 32'h1000_1004, 1'b1, 1'b0);

        @(posedge clk);
        #1;
        chk("R10 idle after last request", 64'(rsp_valid), 64'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule